// File: doc/BRIEF.md
# Cell Bus Frame Arbiter

This block is the single central arbiter of a shared 32-bit cell bus on which up to 32 ports exchange cells. It counts out fixed frames of 16 bus clocks, one cell per frame, and marks the start of each frame, or each pair of frames, with an active-low sync pulse. Every port asks for the bus by raising its own pair of data lines during the first cycle of a frame. The arbiter samples those lines, makes a round-robin choice while the current cell is still moving, and places the chosen port number on the low data lines in the last cycle of the frame. That port sends its cell in the following frame.

Two user modes exist. With 16 users every frame opens with a request cycle for ports 0 to 15. With 32 users frames are paired. The first request cycle of the pair carries ports 0 to 15 and the second carries ports 16 to 31, which reuse the same line pairs. Each decision uses the most recent sample of both halves. An active-low enable makes this device the arbiter. Only one device on a bus may have it asserted. The mode input is held steady while the arbiter is enabled and is changed only under reset.

Top module: `cellbus_arbiter`

## Requirements
- R1: In 16-user mode `frameSyncN` is low for exactly one cycle, the first cycle of each frame, and repeats every 16 cycles.
- R2: In 32-user mode `frameSyncN` is low only in the first cycle of the first frame of each pair, so it repeats every 32 cycles.
- R3: While `rstN` is low, `frameSyncN` is high, `busOe` is low and `busOut` is zero. With the enable asserted, the first sync cycle is the cycle that follows the first clock edge after reset is released.
- R4: Port n (n < 16) requests when bus bit 2n or bit 2n+1 is 1 in the request cycle, which is cycle 0 of a frame. Bus data in every other cycle has no effect on any grant.
- R5: In cycle 15 of every frame `busOe` is 1. `busOut[4:0]` holds the granted port, `busOut[5]` is the valid flag, and bits 31:6 are 0. In all other cycles `busOe` is 0 and `busOut` is 0.
- R6: The grant goes to the first requesting port found by searching upward, with wraparound, from a start pointer. The pointer is 0 after reset and becomes winner+1, modulo the number of ports in the mode, after each valid grant.
- R7: If no port is requesting when the decision is taken, the grant cycle carries valid flag 0, and that frame carries no cell.
- R8: In 32-user mode port 16+m requests through bits 2m and 2m+1 in cycle 0 of the second frame of the pair. Each decision, taken in cycle 1 of every frame, uses the latest sample of both halves. A granted port's request is dropped until its half is sampled again.
- R9: While `arbEnN` is high, `frameSyncN` stays high and the bus is not driven, and held requests are discarded. After the enable returns, frame timing restarts: the first sync is the cycle after the first clock edge that sees the enable low. The search pointer is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| arbEnN | input | 1 | Active-low enable that makes this device the arbiter |
| mode32 | input | 1 | 1 selects 32-user mode, 0 selects 16-user mode |
| busIn | input | 32 | Shared data bus as seen by the arbiter |
| busOut | output | 32 | Grant word driven onto the bus |
| busOe | output | 1 | High in the cycle the arbiter drives the bus |
| frameSyncN | output | 1 | Active-low frame sync |

## Verification
The bench targets request lines that are active in only one bit of a pair, for example bit 31 alone for port 15. A decoder that looked at only one line of the pair would never grant such a port. Frames with no requests must show a clear valid flag. A design that reused a stale winner would instead grant a port that never asked. In 32-user mode, ports 15 and 31 share the same lines in different request cycles, so a design that mixed up the halves or dropped the upper sample would grant the wrong port or skip ports 16 to 31. The bench also drops the enable mid-frame and checks that the sync and the bus go quiet and that timing restarts from a fresh frame. A design that kept counting through the disabled window would put its sync pulse in the wrong cycle.

// File: rtl/cbarb_pkg.sv
package cbarb_pkg;

  // Per-cycle strobes decoded by the control and consumed by the datapath.
  typedef struct packed {
    logic live;    // arbiter enabled and framing
    logic fsync;   // first cycle of a frame (pair in 32-user mode)
    logic reqLo;   // request cycle carrying ports of the lower half
    logic reqHi;   // request cycle carrying ports of the upper half
    logic decide;  // latch the round-robin choice
    logic grant;   // drive the grant word
  } cbStrobe_t;

endpackage

// File: rtl/cbarb_ctrl.sv
module cbarb_ctrl
  import cbarb_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      arbEnN,
  input  logic      mode32,
  output cbStrobe_t strb,
  output logic      frameSyncN
);

  localparam int unsigned PHASE_W = $clog2(2 * FRAME_LEN);
  localparam int unsigned LOW_W   = $clog2(FRAME_LEN);

  logic               live;
  logic [PHASE_W-1:0] cnt;
  logic [LOW_W-1:0]   lowPhase;
  logic               lastCycle;

  assign lowPhase  = cnt[LOW_W-1:0];
  assign lastCycle = mode32 ? (cnt == PHASE_W'(2 * FRAME_LEN - 1))
                            : (cnt == PHASE_W'(FRAME_LEN - 1));

  // live follows the enable one edge late; the phase counter is held at 0
  // whenever framing is off so that each start opens a fresh frame.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      live <= 1'b0;
      cnt  <= '0;
    end else begin
      live <= ~arbEnN;
      if (!live || lastCycle) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strb        = '0;
    strb.live   = live;
    strb.fsync  = live && (cnt == '0);
    strb.reqLo  = live && (cnt == '0);
    strb.reqHi  = live && mode32 && (cnt == PHASE_W'(FRAME_LEN));
    strb.decide = live && (lowPhase == LOW_W'(1));
    strb.grant  = live && (lowPhase == LOW_W'(FRAME_LEN - 1));
  end

  assign frameSyncN = ~strb.fsync;

  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !frameSyncN |=> frameSyncN);  // R1
  AST_FIRST_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (live && !$past(live)) |-> !frameSyncN);  // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.reqLo | strb.reqHi, strb.decide, strb.grant}));  // R5

endmodule

// File: rtl/cbarb_dp.sv
module cbarb_dp
  import cbarb_pkg::*;
#(
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mode32,
  input  cbStrobe_t        strb,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe
);

  localparam int unsigned PORTS  = BUS_W;       // two lines per port, two halves
  localparam int unsigned HALF   = BUS_W / 2;
  localparam int unsigned PORT_W = $clog2(PORTS);

  logic [PORTS-1:0]  reqVec;
  logic [HALF-1:0]   halfReq;
  logic [PORT_W-1:0] ptr;
  logic [PORT_W-1:0] winner;
  logic              winValid;
  logic [PORT_W-1:0] pick;
  logic              found;
  logic [PORT_W-1:0] idx;
  logic [PORT_W-1:0] nextPtr;

  // Either line of a port's pair signals a request.
  for (genvar g = 0; g < HALF; g++) begin : gPair
    assign halfReq[g] = busIn[2*g] | busIn[2*g+1];
  end

  // Round-robin search upward from ptr with wraparound over all ports.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = '0;
    for (int k = 0; k < PORTS; k++) begin
      idx = ptr + PORT_W'(k);
      if (!found && reqVec[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  always_comb begin
    nextPtr = winner + 1'b1;
    if (!mode32) nextPtr[PORT_W-1] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqVec   <= '0;
      ptr      <= '0;
      winner   <= '0;
      winValid <= 1'b0;
    end else if (!strb.live) begin
      reqVec   <= '0;
      winValid <= 1'b0;
    end else begin
      if (strb.reqLo) begin
        reqVec[HALF-1:0] <= halfReq;
        if (!mode32) reqVec[PORTS-1:HALF] <= '0;
      end
      if (strb.reqHi) reqVec[PORTS-1:HALF] <= halfReq;
      if (strb.decide) begin
        winner   <= pick;
        winValid <= found;
      end
      if (strb.grant && winValid) begin
        reqVec[winner] <= 1'b0;
        ptr            <= nextPtr;
      end
    end
  end

  assign busOe  = strb.grant;
  assign busOut = strb.grant ? BUS_W'({winValid, winner}) : '0;

  AST_WINNER_STILL_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.grant && winValid) |-> reqVec[winner]);  // R6
  AST_PTR_IN_HALF: assert property (@(posedge clk) disable iff (!rstN)
    !mode32 |-> !ptr[PORT_W-1]);  // R6
  AST_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!mode32 && strb.decide) |-> (reqVec[PORTS-1:HALF] == '0));  // R8
  AST_NO_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !strb.live |-> (!busOe && busOut == '0));  // R9

endmodule

// File: rtl/cellbus_arbiter.sv
module cellbus_arbiter
  import cbarb_pkg::*;
#(
  parameter int unsigned BUS_W     = 32,
  parameter int unsigned FRAME_LEN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arbEnN,
  input  logic             mode32,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  output logic             frameSyncN
);

  cbStrobe_t strb;

  cbarb_ctrl #(.FRAME_LEN(FRAME_LEN)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .arbEnN     (arbEnN),
    .mode32     (mode32),
    .strb       (strb),
    .frameSyncN (frameSyncN)
  );

  cbarb_dp #(.BUS_W(BUS_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .mode32 (mode32),
    .strb   (strb),
    .busIn  (busIn),
    .busOut (busOut),
    .busOe  (busOe)
  );

endmodule

// File: tb/sim_cellbus_arbiter.sv
module sim_cellbus_arbiter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        arbEnN = 1'b0;
  logic        mode32 = 1'b0;
  logic [31:0] busIn = '0;
  logic [31:0] busOut;
  logic        busOe;
  logic        frameSyncN;

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;

  // reference model state
  bit [31:0] mReq;
  int        mPtr;
  int        mWin;
  bit        mValid;
  int        pos;
  bit        firstCyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  cellbus_arbiter u0 (
    .clk(clk), .rstN(rstN), .arbEnN(arbEnN), .mode32(mode32),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .frameSyncN(frameSyncN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s pos=%0d actual=%h expected=%h", tag, pos, act, exp);
    end
  endtask

  function automatic bit [15:0] pairs(input logic [31:0] v);
    bit [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[2*i] | v[2*i+1];
    return r;
  endfunction

  function automatic int pickNext(input bit [31:0] rq, input int start);
    for (int k = 0; k < 32; k++) begin
      if (rq[(start + k) % 32]) return (start + k) % 32;
    end
    return -1;
  endfunction

  // One bus cycle: check outputs, advance model, drive next bus value.
  // kind 0 = random sparse, 1 = fixed value
  task automatic stepCycle(input int kind, input logic [31:0] val);
    int len;
    int low;
    logic [31:0] v;
    int w;
    @(negedge clk);
    len = mode32 ? 32 : 16;
    low = pos % 16;
    if (firstCyc) chk("R3 first sync", {31'b0, frameSyncN}, 32'd0);
    firstCyc = 0;
    if (mode32) chk("R2 sync", {31'b0, frameSyncN}, (pos == 0) ? 32'd0 : 32'd1);
    else        chk("R1 sync", {31'b0, frameSyncN}, (pos == 0) ? 32'd0 : 32'd1);
    if (low == 15) begin
      chk("R5 oe", {31'b0, busOe}, 32'd1);
      if (mode32) chk("R8 grant", busOut, {26'b0, mValid, 5'(mWin)});
      else if (mValid) chk("R6 grant", busOut, {26'b0, mValid, 5'(mWin)});
      else chk("R7 grant", busOut, {26'b0, mValid, 5'(mWin)});
      if (mValid) begin
        mReq[mWin] = 1'b0;
        mPtr = (mWin + 1) % len;
      end
    end else begin
      chk("R5 oe", {31'b0, busOe}, 32'd0);
      chk("R5 quiet", busOut, 32'd0);
    end
    v = (kind == 0) ? ($urandom & $urandom & $urandom) : val;
    busIn = v;
    if (pos == 0) begin
      mReq[15:0] = pairs(v);
      if (!mode32) mReq[31:16] = '0;
    end
    if (mode32 && pos == 16) mReq[31:16] = pairs(v);
    if (low == 1) begin
      w = pickNext(mReq, mPtr);
      mValid = (w >= 0);
      mWin = (w >= 0) ? w : 0;
    end
    pos = (pos + 1) % len;
  endtask

  task automatic runFrames(input int n, input int kind, input logic [31:0] val);
    for (int i = 0; i < n * 16; i++) stepCycle(kind, val);
  endtask

  task automatic doReset(input bit m32);
    @(negedge clk);
    rstN = 1'b0;
    mode32 = m32;
    arbEnN = 1'b0;
    busIn = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 sync in reset", {31'b0, frameSyncN}, 32'd1);
      chk("R3 oe in reset", {31'b0, busOe}, 32'd0);
      chk("R3 bus in reset", busOut, 32'd0);
    end
    rstN = 1'b1;
    mReq = '0; mPtr = 0; mWin = 0; mValid = 0; pos = 0; firstCyc = 1;
  endtask

  initial begin
    void'($urandom(32'd20517));
    // 16-user mode
    doReset(1'b0);
    runFrames(2, 1, 32'h0);                 // R7 nobody asks
    runFrames(4, 1, 32'hFFFF_FFFF);         // R6 rotation 0,1,2,...
    runFrames(3, 1, 32'h8000_0000);         // R4 port 15 through bit 31 only
    runFrames(3, 1, 32'h0000_0040);         // R4 port 3 through bit 6 only
    runFrames(40, 0, 32'h0);                // random traffic
    // R9 disable in mid frame
    for (int i = 0; i < 7; i++) stepCycle(0, 32'h0);
    arbEnN = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      busIn = $urandom;
      chk("R9 sync off", {31'b0, frameSyncN}, 32'd1);
      chk("R9 oe off", {31'b0, busOe}, 32'd0);
      chk("R9 bus off", busOut, 32'd0);
    end
    arbEnN = 1'b0;
    mReq = '0; mValid = 0; mWin = 0; pos = 0; firstCyc = 1;
    runFrames(6, 0, 32'h0);
    // 32-user mode
    doReset(1'b1);
    runFrames(4, 1, 32'h8000_0000);         // R8 ports 15 and 31 share bit 31
    runFrames(4, 1, 32'h0);                 // R7
    runFrames(6, 1, 32'hFFFF_FFFF);         // R8 full rotation across halves
    runFrames(60, 0, 32'h0);
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!doneFlag) begin
      doneFlag = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule